// File: doc/BRIEF.md
# Synchronous Serial Master Transceiver

This block is the clock-owning side of a synchronous serial link that carries UART-style frames. It drives a bit clock next to its serial output, so the far end never has to recover timing from the data. A word offered on a valid/ready transmit stream is sent as one frame. The frame starts with a start bit, carries a configurable number of data bits, can add a parity bit, and ends with one or two stop bits.

The bit clock toggles only while a frame is in flight. For that reason, every transmitted frame also clocks in one receive frame of the same format from the serial input line. That word comes out on a one-cycle receive strobe, together with a framing-error flag and a parity-error flag.

The bit rate is set by a half-bit divider in system clocks. With a suitable divider, any rate from 4800 bit/s to 115200 bit/s can be reached from a typical system clock. All settings are captured when a word is accepted and are held for the whole frame.

Top module: `usrt_master`

## Requirements
- R1: A frame is a start bit of 0, then the data bits least-significant first, then an optional parity bit, then one stop bit of 1. Between frames the data line rests at 1.
- R2: The data-bit count per frame equals `cfg_bits` when it lies in 4..DATA_W (16 by default). A value below 4 gives 4 bits, and a value above DATA_W gives DATA_W bits. Transmit data bits above the count are not sent.
- R3: The bit clock rests high between frames. During a frame, each bit holds the clock low for `cfg_half`+1 system cycles and then high for `cfg_half`+1 cycles, so one bit lasts 2*(`cfg_half`+1) cycles.
- R4: The transmit line changes only together with a falling bit-clock edge, or when it returns to 1 at frame end. The receive line is sampled at each rising bit-clock edge.
- R5: With `cfg_par_en` set, a parity bit follows the last data bit. With `cfg_par_odd`=0, that bit is the XOR of the data bits (even parity). With `cfg_par_odd`=1, it is the inverse of that XOR (odd parity).
- R6: With `cfg_two_stop` set, the frame ends with two stop bits instead of one.
- R7: `tx_ready` is high only while no frame is in flight. A word is taken when `tx_valid` and `tx_ready` are both high. The data and all `cfg_*` inputs are captured at that moment, and later changes to them leave the current frame unchanged.
- R8: Each transmitted frame clocks in one receive frame of the same format. `rx_valid` pulses for one cycle, in the cycle in which `tx_ready` returns high. At that pulse, `rx_data` holds the received data bits, with all bits above the count at 0.
- R9: `rx_ferr` is set with the word when the received start bit is 1 or any received stop bit is 0.
- R10: `rx_perr` is set with the word when parity is enabled and the received parity bit does not match the received data under the chosen sense. It is 0 when parity is disabled.
- R11: While `rst` is high, and on the cycle after it, `usrt_clk`=1, `usrt_txd`=1, `tx_ready`=1 and `rx_valid`=0. This holds even when reset arrives in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_half | input | DIV_W | Half-bit length in system cycles, minus one |
| cfg_bits | input | $clog2(DATA_W+1) | Data bits per frame |
| cfg_par_en | input | 1 | Add a parity bit |
| cfg_par_odd | input | 1 | Parity sense: 1 = odd, 0 = even |
| cfg_two_stop | input | 1 | Use two stop bits |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Block is idle and takes a word |
| tx_data | input | DATA_W | Transmit word |
| rx_valid | output | 1 | One-cycle strobe for a received word |
| rx_data | output | DATA_W | Received data bits |
| rx_ferr | output | 1 | Received framing error |
| rx_perr | output | 1 | Received parity error |
| usrt_clk | output | 1 | Generated bit clock |
| usrt_txd | output | 1 | Serial data out |
| usrt_rxd | input | 1 | Serial data in |

## Verification
The assertions assume that reset is applied before the first frame. They also assume that the serial input matters only at rising bit-clock edges inside a frame, so they place no constraint on `usrt_rxd` or on the configuration inputs at any other time. The bench changes the settings only while the block is idle, with one exception: a deliberate mid-frame disturbance that checks the capture rule. The bench's target model moves the receive line only on falling bit-clock edges, which keeps that line stable across every rising edge where it is sampled.

// File: rtl/usrt_pkg.sv
package usrt_pkg;
  localparam int MIN_BITS = 4;

  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic two_stop;
  } usrt_opt_t;
endpackage

// File: rtl/usrt_halftimer.sv
module usrt_halftimer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= limit));
endmodule

// File: rtl/usrt_framer.sv
module usrt_framer
  import usrt_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int BW      = 5,
  parameter int FRAME_W = 20,
  parameter int LEN_W   = 5
) (
  input  logic [DATA_W-1:0]  data,
  input  logic [BW-1:0]      nbits,
  input  usrt_opt_t          opt,
  output logic [FRAME_W-1:0] frame,
  output logic [LEN_W-1:0]   flen
);
  logic par;

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    par      = opt.par_odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(nbits)) begin
        frame[i+1] = data[i];
        par        = par ^ data[i];
      end
    end
    if (opt.par_en) begin
      for (int j = 1; j < FRAME_W; j++) begin
        if (j == int'(nbits) + 1) frame[j] = par;
      end
    end
    flen = LEN_W'(nbits) + LEN_W'(2) + LEN_W'(opt.par_en) + LEN_W'(opt.two_stop);
  end
endmodule

// File: rtl/usrt_deframer.sv
module usrt_deframer
  import usrt_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int BW      = 5,
  parameter int FRAME_W = 20
) (
  input  logic [FRAME_W-1:0] bits,
  input  logic [BW-1:0]      nbits,
  input  usrt_opt_t          opt,
  output logic [DATA_W-1:0]  data,
  output logic               ferr,
  output logic               perr
);
  logic par, pbit, stop0, stop1;
  int   stop_pos;

  always_comb begin
    data  = '0;
    par   = opt.par_odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(nbits)) begin
        data[i] = bits[i+1];
        par     = par ^ bits[i+1];
      end
    end
    stop_pos = int'(nbits) + 1 + (opt.par_en ? 1 : 0);
    pbit  = 1'b0;
    stop0 = 1'b1;
    stop1 = 1'b1;
    for (int j = 0; j < FRAME_W; j++) begin
      if (j == int'(nbits) + 1) pbit  = bits[j];
      if (j == stop_pos)        stop0 = bits[j];
      if (j == stop_pos + 1)    stop1 = bits[j];
    end
    ferr = bits[0] | ~stop0 | (opt.two_stop & ~stop1);
    perr = opt.par_en & (par ^ pbit);
  end
endmodule

// File: rtl/usrt_master.sv
module usrt_master
  import usrt_pkg::*;
#(
  parameter  int DATA_W = 16,
  parameter  int DIV_W  = 16,
  localparam int BW     = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  cfg_half,
  input  logic [BW-1:0]     cfg_bits,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ferr,
  output logic              rx_perr,
  output logic              usrt_clk,
  output logic              usrt_txd,
  input  logic              usrt_rxd
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  logic [BW-1:0]      eff_bits;
  usrt_opt_t          opt_new, opt_q;
  logic [FRAME_W-1:0] frame_new, frame_q, rxsh_q;
  logic [LEN_W-1:0]   flen_new, flen_q, idx_q;
  logic [BW-1:0]      nb_q;
  logic [DIV_W-1:0]   half_q;
  logic               busy, tick;
  logic [DATA_W-1:0]  dec_data;
  logic               dec_ferr, dec_perr;

  always_comb begin
    if (cfg_bits < BW'(MIN_BITS))    eff_bits = BW'(MIN_BITS);
    else if (cfg_bits > BW'(DATA_W)) eff_bits = BW'(DATA_W);
    else                             eff_bits = cfg_bits;
  end

  assign opt_new = '{par_en: cfg_par_en, par_odd: cfg_par_odd, two_stop: cfg_two_stop};

  usrt_framer #(.DATA_W(DATA_W), .BW(BW), .FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_framer (
    .data(tx_data), .nbits(eff_bits), .opt(opt_new), .frame(frame_new), .flen(flen_new)
  );

  usrt_halftimer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst(rst), .run(busy), .limit(half_q), .tick(tick)
  );

  usrt_deframer #(.DATA_W(DATA_W), .BW(BW), .FRAME_W(FRAME_W)) u_deframer (
    .bits(rxsh_q), .nbits(nb_q), .opt(opt_q), .data(dec_data), .ferr(dec_ferr), .perr(dec_perr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      tx_ready <= 1'b1;
      usrt_clk <= 1'b1;
      usrt_txd <= 1'b1;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_ferr  <= 1'b0;
      rx_perr  <= 1'b0;
      frame_q  <= '1;
      rxsh_q   <= '1;
      flen_q   <= '0;
      idx_q    <= '0;
      nb_q     <= '0;
      half_q   <= '0;
      opt_q    <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (!busy) begin
        if (tx_valid) begin
          busy     <= 1'b1;
          tx_ready <= 1'b0;
          frame_q  <= frame_new;
          flen_q   <= flen_new;
          nb_q     <= eff_bits;
          opt_q    <= opt_new;
          half_q   <= cfg_half;
          idx_q    <= '0;
          usrt_clk <= 1'b0;
          usrt_txd <= frame_new[0];
        end
      end else if (tick) begin
        if (!usrt_clk) begin
          usrt_clk       <= 1'b1;
          rxsh_q[idx_q]  <= usrt_rxd;
        end else if (idx_q == flen_q - 1'b1) begin
          busy     <= 1'b0;
          tx_ready <= 1'b1;
          usrt_txd <= 1'b1;
          rx_valid <= 1'b1;
          rx_data  <= dec_data;
          rx_ferr  <= dec_ferr;
          rx_perr  <= dec_perr;
        end else begin
          idx_q    <= idx_q + 1'b1;
          usrt_clk <= 1'b0;
          usrt_txd <= frame_q[idx_q + 1'b1];
        end
      end
    end
  end

  assert_start_low_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_ready) |-> (!usrt_txd && !usrt_clk));
  assert_idle_high_R3: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> (usrt_clk && usrt_txd));
  assert_txd_edge_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(usrt_txd) |-> ($fell(usrt_clk) || $rose(tx_ready)));
  assert_rx_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  assert_rx_at_end_R8: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (tx_ready && $rose(tx_ready)));
endmodule

// File: tb/usrt_master_test.sv
module usrt_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int FW = DW + 4;
  localparam int NV = 8;

  typedef struct packed {
    logic [4:0]  bits;
    logic        pe, po, ts;
    logic [3:0]  half;
    logic [15:0] txd, rxd;
    logic        bst, bsp, bpa;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{5'd8,  1'b0, 1'b0, 1'b0, 4'd1, 16'h00A5, 16'h003C, 1'b0, 1'b0, 1'b0},
    '{5'd4,  1'b1, 1'b0, 1'b0, 4'd0, 16'h000B, 16'h0006, 1'b0, 1'b0, 1'b0},
    '{5'd16, 1'b1, 1'b1, 1'b1, 4'd2, 16'hBEEF, 16'h1234, 1'b0, 1'b0, 1'b0},
    '{5'd12, 1'b0, 1'b0, 1'b1, 4'd1, 16'h0ABC, 16'h0FFF, 1'b0, 1'b1, 1'b0},
    '{5'd7,  1'b1, 1'b0, 1'b0, 4'd1, 16'h007F, 16'h0055, 1'b0, 1'b0, 1'b1},
    '{5'd9,  1'b1, 1'b1, 1'b0, 4'd3, 16'h0100, 16'h01FF, 1'b1, 1'b0, 1'b0},
    '{5'd2,  1'b0, 1'b0, 1'b0, 4'd0, 16'hFFF3, 16'h0005, 1'b0, 1'b0, 1'b0},
    '{5'd31, 1'b1, 1'b1, 1'b0, 4'd0, 16'h8001, 16'hA5A5, 1'b0, 1'b0, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [15:0]   cfg_half = '0;
  logic [4:0]    cfg_bits = 5'd8;
  logic          cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
  logic          tx_valid = 1'b0;
  logic          tx_ready;
  logic [DW-1:0] tx_data = '0;
  logic          rx_valid;
  logic [DW-1:0] rx_data;
  logic          rx_ferr, rx_perr;
  logic          usrt_clk, usrt_txd;
  logic          usrt_rxd = 1'b1;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  usrt_master #(.DATA_W(DW), .DIV_W(16)) uut (
    .clk(clk), .rst(rst), .cfg_half(cfg_half), .cfg_bits(cfg_bits),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ferr(rx_ferr), .rx_perr(rx_perr),
    .usrt_clk(usrt_clk), .usrt_txd(usrt_txd), .usrt_rxd(usrt_rxd)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int eff_bits(input int b);
    if (b < 4) return 4;
    if (b > DW) return DW;
    return b;
  endfunction

  function automatic logic [FW-1:0] build(input logic [15:0] d, input int n, input logic pe,
                                          input logic po, input logic ts, output int len);
    logic [FW-1:0] f;
    int pos;
    logic x;
    f = '1; pos = 0; x = 1'b0;
    f[pos] = 1'b0; pos++;
    for (int i = 0; i < n; i++) begin
      f[pos] = d[i]; x = x ^ d[i]; pos++;
    end
    if (pe) begin f[pos] = x ^ po; pos++; end
    f[pos] = 1'b1; pos++;
    if (ts) begin f[pos] = 1'b1; pos++; end
    len = pos;
    return f;
  endfunction

  task automatic run_frame(input vec_t v, input bit disturb);
    int n, len, rlen, got;
    logic [FW-1:0] exp_f, rx_f, cap;
    logic [DW-1:0] exp_rx;
    time tf0, tf1, tr0;
    logic ready_mid;
    n = eff_bits(int'(v.bits));
    exp_f = build(v.txd, n, v.pe, v.po, v.ts, len);
    rx_f  = build(v.rxd, n, v.pe, v.po, v.ts, rlen);
    if (v.bst) rx_f[0] = 1'b1;
    if (v.bsp) rx_f[rlen-1] = 1'b0;
    if (v.bpa) rx_f[n+1] = ~rx_f[n+1];
    exp_rx = v.rxd & DW'((32'd1 << n) - 1);
    cap = '1; tf0 = 0; tf1 = 0; tr0 = 0; ready_mid = 1'b1;
    @(negedge clk);
    cfg_bits = v.bits; cfg_par_en = v.pe; cfg_par_odd = v.po; cfg_two_stop = v.ts;
    cfg_half = 16'(v.half); tx_data = v.txd; tx_valid = 1'b1;
    for (int k = 0; k < len; k++) begin
      @(negedge usrt_clk);
      if (k == 0) begin tf0 = $time; if (!disturb) tx_valid = 1'b0; end
      if (k == 1) tf1 = $time;
      usrt_rxd = rx_f[k];
      @(posedge usrt_clk);
      if (k == 0) tr0 = $time;
      cap[k] = usrt_txd;
      if (disturb && k == 1) begin
        ready_mid = tx_ready;
        tx_data = ~tx_data; cfg_bits = 5'd5; cfg_two_stop = ~cfg_two_stop; cfg_par_en = ~cfg_par_en;
        cfg_half = 16'd7;
      end
      if (k == len - 1) tx_valid = 1'b0;
    end
    usrt_rxd = 1'b1;
    got = 0;
    for (int g = 0; g < 200; g++) begin
      @(negedge clk);
      if (rx_valid) begin got = 1; break; end
    end
    // R1 R2 R5 R6 R7: transmitted frame bits
    check(cap == exp_f, disturb ? "R7 frame unaffected by mid-frame changes" : "R1 R2 R5 R6 tx frame",
          32'(cap), 32'(exp_f));
    // R3: bit timing
    check((tr0 - tf0 == time'((v.half + 1) * CLK_PERIOD)) &&
          (tf1 - tf0 == time'(2 * (v.half + 1) * CLK_PERIOD)),
          "R3 bit clock timing", 32'(tf1 - tf0), 32'(2 * (v.half + 1) * CLK_PERIOD));
    check(got == 1, "R8 rx_valid seen", 32'(got), 32'd1);
    check(rx_data == exp_rx, "R8 R4 rx_data", 32'(rx_data), 32'(exp_rx));
    check(rx_ferr == (v.bst | v.bsp), "R9 rx_ferr", 32'(rx_ferr), 32'(v.bst | v.bsp));
    check(rx_perr == (v.pe & v.bpa), "R10 rx_perr", 32'(rx_perr), 32'(v.pe & v.bpa));
    check(tx_ready && usrt_clk && usrt_txd, "R1 R3 R7 idle after frame",
          {29'd0, tx_ready, usrt_clk, usrt_txd}, 32'd7);
    if (disturb) check(ready_mid == 1'b0, "R7 tx_ready low mid-frame", 32'(ready_mid), 32'd0);
    @(negedge clk);
    check(rx_valid == 1'b0, "R8 rx_valid single cycle", 32'(rx_valid), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: state during reset
    check(usrt_clk && usrt_txd && tx_ready && !rx_valid, "R11 reset state",
          {28'd0, usrt_clk, usrt_txd, tx_ready, rx_valid}, 32'hE);
    rst = 1'b0;
    @(negedge clk);
    check(usrt_clk && usrt_txd && tx_ready && !rx_valid, "R11 after reset release",
          {28'd0, usrt_clk, usrt_txd, tx_ready, rx_valid}, 32'hE);

    for (int i = 0; i < NV; i++) run_frame(VEC[i], 1'b0);

    // R7: mid-frame changes to data and config have no effect
    run_frame(VEC[0], 1'b1);

    // R11: reset in the middle of a frame
    @(negedge clk);
    cfg_half = 16'd3; cfg_bits = 5'd8; tx_data = 16'h0F0F; tx_valid = 1'b1;
    repeat (6) @(negedge clk);
    check(tx_ready == 1'b0, "R7 busy during frame", 32'(tx_ready), 32'd0);
    rst = 1'b1; tx_valid = 1'b0;
    @(negedge clk);
    check(usrt_clk && usrt_txd && tx_ready && !rx_valid, "R11 reset mid-frame",
          {28'd0, usrt_clk, usrt_txd, tx_ready, rx_valid}, 32'hE);
    rst = 1'b0;
    @(negedge clk);
    check(usrt_clk && usrt_txd && tx_ready, "R11 idle after mid-frame reset",
          {29'd0, usrt_clk, usrt_txd, tx_ready}, 32'h7);

    // R2 R8: frame after reset still uses clamped width
    run_frame(VEC[6], 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule